// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a branch condition holds. A 4-bit selector picks one of sixteen conditions. The block tests that condition against the flag bits of the processor status word and drives two results. One is a single-bit branch-taken signal. The other is a data-width word that holds exactly 1 or 0, ready to be written to a destination register by a set-on-condition instruction.

The block is purely combinational. When the flags of the most recent ALU operation have not yet been written into the status word, the caller raises `use_fast`. For the four conditions that depend only on the zero-ness or sign of that result, the block then looks at the ALU result word directly. Every other condition always reads the status word. Producing the flags and computing branch targets are left to neighbouring logic.

Top module: `brcond_eval`

## Requirements
- R1: Flags sit in the status word as C at bit 0, V at bit 1, Z at bit 2 and N at bit 3. With selector codes 0 CC, 1 CS, 2 NE, 3 EQ, 4 VC, 5 VS, 6 PL, 7 MI, each condition is true as follows: CC when C=0, CS when C=1, NE when Z=0, EQ when Z=1, VC when V=0, VS when V=1, PL when N=0, MI when N=1.
- R2: Code 8 (LS) is true when C or Z is set. Code 9 (HI) is true only when both C and Z are clear.
- R3: Code 10 (GE) is true when N equals V. Code 11 (LT) is true when N differs from V.
- R4: Code 12 (GT) is true when Z is clear and N equals V. Code 13 (LE) is true when Z is set or N differs from V.
- R5: Code 14 (always) is true for any status value. Code 15 tests the P flag at status bit P_BIT (default 7).
- R6: `set_value` equals 1 when `taken` is 1 and 0 otherwise. All bits above bit 0 are zero.
- R7: When `use_fast` is 1, code 3 (EQ) is true exactly when `alu_res` is zero, and code 2 (NE) exactly when `alu_res` is nonzero. The status word is ignored for these codes.
- R8: When `use_fast` is 1, code 7 (MI) is true when the most significant bit of `alu_res` is set, and code 6 (PL) when it is clear.
- R9: With `use_fast` at 0, `alu_res` has no effect on any condition. With `use_fast` at 1, codes other than 2, 3, 6 and 7 still read only the status word. Status bits other than 0 to 3 and P_BIT never affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cond_sel | input | 4 | Condition selector code |
| status | input | STAT_W (16) | Status word holding the flags |
| use_fast | input | 1 | Flags not yet materialised; use ALU result for EQ/NE/PL/MI |
| alu_res | input | DATA_W (32) | Result of the most recent ALU operation |
| taken | output | 1 | Condition holds |
| set_value | output | DATA_W (32) | 1 or 0 word for set-on-condition |

## Verification
The bench sweeps every selector code against all combinations of the four arithmetic flags and the P flag. Both settings of `use_fast` are applied with ALU results that are zero, one, the most negative value, the most positive value and all ones. Noise is placed in the unused status bits. Specific failures the sweep exposes:
- A design that swaps a flag position, or mixes up which code of a complementary pair is the set test, fails whole columns of the sweep.
- A signed compare built from N alone, without V, misses the rows where V is set.
- A fast path that tests the low bit instead of the sign bit fails PL/MI on the patterns 1 and 0x80000000.
- Letting the ALU result leak into the slow conditions makes HI, GT or the always condition wrong with `use_fast` raised.
- A set-on-condition result that passes the raw masked flag bit instead of a clean 1 gives values such as 4 or 8.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

   localparam int NUM_COND = 16;
   localparam int SEL_W    = $clog2(NUM_COND);

   localparam int C_POS = 0;
   localparam int V_POS = 1;
   localparam int Z_POS = 2;
   localparam int N_POS = 3;

   typedef enum logic [SEL_W-1:0] {
      COND_CC = 4'd0,
      COND_CS = 4'd1,
      COND_NE = 4'd2,
      COND_EQ = 4'd3,
      COND_VC = 4'd4,
      COND_VS = 4'd5,
      COND_PL = 4'd6,
      COND_MI = 4'd7,
      COND_LS = 4'd8,
      COND_HI = 4'd9,
      COND_GE = 4'd10,
      COND_LT = 4'd11,
      COND_GT = 4'd12,
      COND_LE = 4'd13,
      COND_AL = 4'd14,
      COND_PF = 4'd15
   } cond_code_e;

   typedef struct packed {
      logic pf;
      logic n;
      logic z;
      logic v;
      logic c;
   } flag_set_t;

   function automatic logic is_fast_code(input logic [SEL_W-1:0] code);
      return (code == COND_EQ) || (code == COND_NE) ||
             (code == COND_PL) || (code == COND_MI);
   endfunction

endpackage

// File: rtl/brcond_flag_eval.sv
module brcond_flag_eval
   import brcond_pkg::*;
(
   input  flag_set_t              flags,
   input  logic [SEL_W-1:0]       cond_sel,
   output logic                   taken
);

   logic [NUM_COND-1:0] truth_vec;
   logic                ls_term;
   logic                sgn_lt;

   always_comb begin
      ls_term = flags.c | flags.z;
      sgn_lt  = flags.n ^ flags.v;
   end

   always_comb begin
      truth_vec          = '0;
      truth_vec[COND_CC] = ~flags.c;
      truth_vec[COND_CS] =  flags.c;
      truth_vec[COND_NE] = ~flags.z;
      truth_vec[COND_EQ] =  flags.z;
      truth_vec[COND_VC] = ~flags.v;
      truth_vec[COND_VS] =  flags.v;
      truth_vec[COND_PL] = ~flags.n;
      truth_vec[COND_MI] =  flags.n;
      truth_vec[COND_LS] =  ls_term;
      truth_vec[COND_HI] = ~flags.c & ~flags.z;
      truth_vec[COND_GE] = ~sgn_lt;
      truth_vec[COND_LT] =  sgn_lt;
      truth_vec[COND_GT] = ~flags.z & ~sgn_lt;
      truth_vec[COND_LE] =  flags.z | sgn_lt;
      truth_vec[COND_AL] =  1'b1;
      truth_vec[COND_PF] =  flags.pf;
   end

   assign taken = truth_vec[cond_sel];

   for (genvar k = 0; k < 7; k++) begin : g_pair_chk
      always_comb begin
         if (!$isunknown(flags)) begin
            AST_PAIR_INV: assert (truth_vec[2*k] != truth_vec[2*k+1]); // R1
         end
      end
   end

   always_comb begin
      if (!$isunknown(flags)) begin
         AST_GT_IMPLIES_GE: assert (!truth_vec[COND_GT] || truth_vec[COND_GE]); // R4
         AST_HI_IMPLIES_CC: assert (!truth_vec[COND_HI] || truth_vec[COND_CC]); // R2
      end
   end

endmodule

// File: rtl/brcond_fast_eval.sv
module brcond_fast_eval
   import brcond_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit FAST_EN = 1'b1
) (
   input  logic [DATA_W-1:0] alu_res,
   input  logic [SEL_W-1:0]  cond_sel,
   input  logic              use_fast,
   output logic              hit,
   output logic              taken
);

   localparam int SIGN_POS = DATA_W - 1;

   if (FAST_EN) begin : g_fast
      logic res_zero;
      logic res_neg;

      assign res_zero = (alu_res == '0);
      assign res_neg  = alu_res[SIGN_POS];

      always_comb begin
         hit   = use_fast && is_fast_code(cond_sel);
         unique case (cond_sel)
            COND_EQ: taken = res_zero;
            COND_NE: taken = ~res_zero;
            COND_MI: taken = res_neg;
            COND_PL: taken = ~res_neg;
            default: taken = 1'b0;
         endcase
      end
   end else begin : g_nofast
      assign hit   = 1'b0;
      assign taken = 1'b0;
   end

endmodule

// File: rtl/brcond_set_fmt.sv
module brcond_set_fmt #(
   parameter int DATA_W = 32
) (
   input  logic              cond_true,
   output logic [DATA_W-1:0] set_value
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == 0) begin : g_lsb
         assign set_value[b] = cond_true;
      end else begin : g_hi
         assign set_value[b] = 1'b0;
      end
   end

endmodule

// File: rtl/brcond_eval.sv
module brcond_eval
   import brcond_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int STAT_W  = 16,
   parameter int P_BIT   = 7,
   parameter bit FAST_EN = 1'b1
) (
   input  logic [3:0]        cond_sel,
   input  logic [STAT_W-1:0] status,
   input  logic              use_fast,
   input  logic [DATA_W-1:0] alu_res,
   output logic              taken,
   output logic [DATA_W-1:0] set_value
);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("brcond_eval: DATA_W must be at least 2");
   end
   if (P_BIT <= N_POS || P_BIT >= STAT_W) begin : g_bad_p_bit
      $error("brcond_eval: P_BIT must lie above the N flag and inside STAT_W");
   end

   flag_set_t flags;
   logic      flag_taken;
   logic      fast_hit;
   logic      fast_taken;

   always_comb begin
      flags.c  = status[C_POS];
      flags.v  = status[V_POS];
      flags.z  = status[Z_POS];
      flags.n  = status[N_POS];
      flags.pf = status[P_BIT];
   end

   brcond_flag_eval u_flag (
      .flags    (flags),
      .cond_sel (cond_sel),
      .taken    (flag_taken)
   );

   brcond_fast_eval #(
      .DATA_W  (DATA_W),
      .FAST_EN (FAST_EN)
   ) u_fast (
      .alu_res  (alu_res),
      .cond_sel (cond_sel),
      .use_fast (use_fast),
      .hit      (fast_hit),
      .taken    (fast_taken)
   );

   assign taken = fast_hit ? fast_taken : flag_taken;

   brcond_set_fmt #(
      .DATA_W (DATA_W)
   ) u_fmt (
      .cond_true (taken),
      .set_value (set_value)
   );

   always_comb begin
      if (!$isunknown({cond_sel, status, use_fast, alu_res})) begin
         AST_SET_ZERO_EXT: assert (set_value[DATA_W-1:1] == '0); // R6
         AST_SET_LSB: assert (set_value[0] == taken); // R6
         AST_ALWAYS_TRUE: assert (cond_sel != COND_AL || taken); // R5
         if (FAST_EN && use_fast && cond_sel == COND_EQ) begin
            AST_FAST_EQ: assert (taken == (alu_res == '0)); // R7
         end
         if (FAST_EN && use_fast && cond_sel == COND_MI) begin
            AST_FAST_SIGN: assert (taken == alu_res[DATA_W-1]); // R8
         end
      end
   end

endmodule

// File: tb/test_brcond_eval.sv
module test_brcond_eval;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 32;
   localparam int STAT_W     = 16;
   localparam int P_BIT      = 7;
   localparam int WDOG_LIM   = 100000;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [3:0]        cond_sel;
   logic [STAT_W-1:0] status;
   logic              use_fast;
   logic [DATA_W-1:0] alu_res;
   logic              taken;
   logic [DATA_W-1:0] set_value;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   brcond_eval #(
      .DATA_W (DATA_W),
      .STAT_W (STAT_W),
      .P_BIT  (P_BIT)
   ) i_brcond_eval (
      .cond_sel  (cond_sel),
      .status    (status),
      .use_fast  (use_fast),
      .alu_res   (alu_res),
      .taken     (taken),
      .set_value (set_value)
   );

   function automatic string req_tag(int cs, bit uf);
      if (uf && (cs == 2 || cs == 3)) return "R7";
      if (uf && (cs == 6 || cs == 7)) return "R8";
      if (cs < 8)  return "R1";
      if (cs < 10) return "R2";
      if (cs < 12) return "R3";
      if (cs < 14) return "R4";
      return "R5";
   endfunction

   function automatic bit exp_taken(int cs, logic [STAT_W-1:0] st, bit uf,
                                    logic [DATA_W-1:0] ar);
      bit c = st[0];
      bit v = st[1];
      bit z = st[2];
      bit n = st[3];
      bit p = st[P_BIT];
      bit az = (ar == 0);
      bit an = ar[DATA_W-1];
      if (uf) begin
         case (cs)
            2: return !az;
            3: return az;
            6: return !an;
            7: return an;
            default: ;
         endcase
      end
      case (cs)
         0:  return !c;
         1:  return c;
         2:  return !z;
         3:  return z;
         4:  return !v;
         5:  return v;
         6:  return !n;
         7:  return n;
         8:  return c || z;
         9:  return !c && !z;
         10: return n == v;
         11: return n != v;
         12: return !z && (n == v);
         13: return z || (n != v);
         14: return 1'b1;
         default: return p;
      endcase
   endfunction

   task automatic check_bit(string tag, bit act, bit exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b (cond=%0d status=%h fast=%0b alu=%h)",
                  tag, what, act, exp, cond_sel, status, use_fast, alu_res);
      end
   endtask

   task automatic check_word(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s set_value: actual %h expected %h (cond=%0d status=%h)",
                  tag, act, exp, cond_sel, status);
      end
   endtask

   task automatic apply(int cs, logic [STAT_W-1:0] st, bit uf, logic [DATA_W-1:0] ar,
                        string tag_override);
      bit    e;
      string tag;
      @(posedge clk);
      cond_sel = cs[3:0];
      status   = st;
      use_fast = uf;
      alu_res  = ar;
      @(negedge clk);
      e   = exp_taken(cs, st, uf, ar);
      tag = (tag_override != "") ? tag_override : req_tag(cs, uf);
      check_bit(tag, taken, e, "taken");
      check_word("R6", set_value, {{(DATA_W-1){1'b0}}, e});
   endtask

   always @(posedge clk) begin
      cycles++;
      if (!done && cycles >= WDOG_LIM) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WDOG_LIM);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DATA_W-1:0] pats [5];
      pats[0] = 32'h0000_0000;
      pats[1] = 32'h0000_0001;
      pats[2] = 32'h8000_0000;
      pats[3] = 32'h7fff_ffff;
      pats[4] = 32'hffff_ffff;

      cond_sel = 4'd0;
      status   = '0;
      use_fast = 1'b0;
      alu_res  = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // Reset-time state: CC with all flags clear holds (R1), word is 1 (R6)
      check_bit("R1", taken, 1'b1, "reset taken");
      check_word("R6", set_value, 32'd1);
      rst = 1'b0;

      // Exhaustive sweep: all codes, flag nibble plus P, both paths, ALU patterns
      for (int cs = 0; cs < 16; cs++) begin
         for (int s = 0; s < 32; s++) begin
            for (int uf = 0; uf < 2; uf++) begin
               for (int pi = 0; pi < 5; pi++) begin
                  logic [STAT_W-1:0] st;
                  st        = '0;
                  st[3:0]   = s[3:0];
                  st[P_BIT] = s[4];
                  // R9: noise in unused status bits must not matter
                  st[6:4]   = s[0] ? 3'b101 : 3'b010;
                  st[15:8]  = s[1] ? 8'hA5 : 8'h5A;
                  apply(cs, st, bit'(uf), pats[pi], "");
               end
            end
         end
      end

      // R9: slow path ignores alu_res; EQ with Z set and nonzero result
      apply(3, 16'h0004, 1'b0, 32'hdead_beef, "R9");
      // R9: fast path leaves HI on status even with a zero result
      apply(9, 16'h0001, 1'b1, 32'h0, "R9");
      // R9: P condition reads only P_BIT, not neighbouring bit 6
      apply(15, 16'h0040, 1'b1, 32'h0, "R9");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule